// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block sits on the controller side of an SDRAM interface and owns two jobs. The first is the mandatory start-up procedure. After reset it holds clock-enable and the data mask high and drives only no-operation commands for a programmable settling wait. It then issues one precharge of every bank, a mode-register load and a group of auto-refresh commands. The mode-register load and the refresh group can come in either order, chosen by a parameter. Each command is spaced from the next by the recovery time of the command before it.

Once start-up is done, `ready` rises and the block becomes a refresh scheduler. An interval counter adds one owed refresh every refresh period. While any refresh is owed, `ref_req` stays high. The access arbiter answers with `ref_grant` once it has closed every bank, and it reports that state on `banks_idle`. The sequencer then issues auto-refresh commands spaced by the row-cycle time until nothing is owed. Refreshes that the arbiter postpones are counted, up to a limit, and are later issued back to back.

All timing values are parameters given in clock cycles, each rounded up from its time figure. For example, 200 µs at 125 MHz is 25000 cycles, and 15.6 µs is 1950 cycles.

Top module: `sdram_init_refresh_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, the outputs are as follows: `cke`=1, `dqm`=1, `ready`=0, `ref_req`=0, and the command pins carry NOP.
- R2: After reset is released, the command pins carry only NOP for `PWR_WAIT_CYC` cycles. The first other command appears in cycle `PWR_WAIT_CYC`+1, counting the first clock edge with `rst_n` high as cycle 1.
- R3: Command encodings are written {cs_n,ras_n,cas_n,we_n}. NOP is 0111. Precharge-all is 0010 with address bit `AP_BIT` (10) set. Mode-register load is 0000 with the address equal to `MODE_WORD` and bank 0. Auto-refresh is 0001.
- R4: The start-up order is a precharge-all first. With `MRS_FIRST`=1 the mode-register load follows, then the refreshes. With `MRS_FIRST`=0 the refreshes follow, and the mode-register load comes last.
- R5: Start-up issues exactly `INIT_REFRESHES` auto-refresh commands. The default is 8.
- R6: During start-up each command follows the previous one after exactly its recovery distance: `T_RP_CYC` after precharge-all, `T_MRD_CYC` after a mode-register load, and `T_RC_CYC` after auto-refresh. No two commands are ever closer than these distances.
- R7: `ready` rises exactly one recovery distance after the last start-up command and then stays high. `dqm` is high while `ready` is low and low once it is high. `cke` is high at all times.
- R8: While `ready` is high, one refresh becomes owed every `REF_INTERVAL_CYC` cycles. The first one is owed `REF_INTERVAL_CYC` cycles after `ready` rises. `ref_req` is high exactly while a refresh is owed.
- R9: A refresh after start-up is issued only one cycle after `ref_grant` and `banks_idle` were both sampled high. It is issued in that cycle whenever a refresh is owed and `T_RC_CYC` has elapsed since the previous command. While `banks_idle` is low, no refresh is issued.
- R10: The owed count saturates at `MAX_POSTPONE`, and extra intervals are dropped. Once granted, the owed refreshes are issued back to back, `T_RC_CYC` apart.
- R11: `ref_req` falls in the same cycle in which the last owed refresh appears on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_grant | input | 1 | Arbiter lets the sequencer issue refresh |
| banks_idle | input | 1 | Arbiter reports every bank precharged |
| ready | output | 1 | Start-up sequence complete |
| ref_req | output | 1 | At least one refresh is owed |
| cke | output | 1 | Clock enable to the memory |
| dqm | output | 1 | Data mask to the memory |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_addr | output | ADDR_W | Address pins |
| cmd_ba | output | BA_W | Bank select pins |

## Verification
On every cycle the assertions check the following:
- the minimum spacing between any two commands, measured from the kind of the earlier one;
- the settling wait before the first command;
- the auto-precharge bit and the mode word;
- that a runtime refresh is always preceded by a sampled grant with idle banks;
- that `ready` stays high once raised, `dqm` follows it, and `ref_req` stays low before `ready`.

Some properties show only in the bench's scenarios, which run two instances with opposite start-up orders. These are the exact cycle of each start-up command, the exact refresh count, the one-refresh-per-interval rate, saturation of postponed refreshes followed by a back-to-back burst, and the hold-off while banks are busy.

// File: rtl/sirs_pkg.sv
// Shared encodings for the SDRAM power-up and refresh sequencer.
// Assumes pins ordered {cs_n, ras_n, cas_n, we_n}.
package sirs_pkg;

    typedef logic [3:0] pins_t;

    localparam pins_t PIN_NOP  = 4'b0111;
    localparam pins_t PIN_PALL = 4'b0010;
    localparam pins_t PIN_MRS  = 4'b0000;
    localparam pins_t PIN_REF  = 4'b0001;

    typedef enum logic [1:0] {
        K_PALL = 2'd0,
        K_MRS  = 2'd1,
        K_REF  = 2'd2
    } step_kind_e;

    typedef enum logic [1:0] {
        ST_INIT  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_RUN   = 2'd2
    } seq_state_e;

    // Maps a command kind to its pin pattern.
    function automatic pins_t pins_for(step_kind_e k);
        case (k)
            K_PALL:  return PIN_PALL;
            K_MRS:   return PIN_MRS;
            default: return PIN_REF;
        endcase
    endfunction

endpackage

// File: rtl/sirs_gap_timer.sv
// Down-counter holding off the next command until a recovery gap expires.
// Loaded with (distance - 1) when a command issues; idle when it reaches zero.
// The reset value doubles as the power-up settling wait.
module sirs_gap_timer #(
    parameter int W       = 8,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         idle
);

    logic [W-1:0] cnt_q;

    // Count down to zero; reload on every issued command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= W'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign idle = (cnt_q == '0);

endmodule

// File: rtl/sirs_init_order.sv
// Decodes the start-up step index into the command kind for that step.
// Step 0 is always precharge-all; a parameter picks where the mode load sits.
module sirs_init_order
    import sirs_pkg::*;
#(
    parameter int INIT_REFRESHES = 8,
    parameter bit MRS_FIRST      = 1'b1,
    parameter int STEP_W         = 4
) (
    input  logic [STEP_W-1:0] step,
    output step_kind_e        kind,
    output logic              last
);

    localparam int LAST_STEP = INIT_REFRESHES + 1;

    generate
        if (MRS_FIRST) begin : g_mrs_first
            // Order: precharge-all, mode load, refresh group.
            always_comb begin
                if (step == '0)             kind = K_PALL;
                else if (step == STEP_W'(1)) kind = K_MRS;
                else                        kind = K_REF;
            end
        end else begin : g_ref_first
            // Order: precharge-all, refresh group, mode load.
            always_comb begin
                if (step == '0)                     kind = K_PALL;
                else if (step == STEP_W'(LAST_STEP)) kind = K_MRS;
                else                                kind = K_REF;
            end
        end
    endgenerate

    assign last = (step == STEP_W'(LAST_STEP));

endmodule

// File: rtl/sirs_refresh_tracker.sv
// Counts refresh intervals while running and keeps a saturating count of
// owed refreshes. Assumes INTERVAL >= 2 and MAX_PEND >= 1.
module sirs_refresh_tracker #(
    parameter int INTERVAL = 1950,
    parameter int MAX_PEND = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic issue,
    output logic pend_nz
);

    localparam int CNT_W  = $clog2(INTERVAL);
    localparam int PEND_W = $clog2(MAX_PEND + 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [PEND_W-1:0] pend_q;
    logic              tick;

    assign tick = run_en && (cnt_q == CNT_W'(INTERVAL - 1));

    // Free-running interval counter, active only once the device is ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run_en) begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
        end
    end

    // Owed-refresh counter: add on tick, remove on issue, clamp at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            case ({tick, issue})
                2'b10:   if (pend_q != PEND_W'(MAX_PEND)) pend_q <= pend_q + 1'b1;
                2'b01:   pend_q <= pend_q - 1'b1;
                default: pend_q <= pend_q;
            endcase
        end
    end

    assign pend_nz = (pend_q != '0);

endmodule

// File: rtl/sdram_init_refresh_seq.sv
// SDRAM power-up and refresh sequencer (top).
// Holds NOP for the settling wait, runs precharge-all / mode load / refresh
// group, then schedules periodic auto-refresh under arbiter grant.
// Assumes the arbiter keeps banks_idle truthful and all timings >= 1 cycle.
module sdram_init_refresh_seq
    import sirs_pkg::*;
#(
    parameter int ADDR_W           = 12,
    parameter int BA_W             = 2,
    parameter int AP_BIT           = 10,
    parameter logic [ADDR_W-1:0] MODE_WORD = 'h032,
    parameter int PWR_WAIT_CYC     = 25000,
    parameter int T_RP_CYC         = 3,
    parameter int T_RC_CYC         = 9,
    parameter int T_MRD_CYC        = 2,
    parameter int INIT_REFRESHES   = 8,
    parameter int REF_INTERVAL_CYC = 1950,
    parameter int MAX_POSTPONE     = 8,
    parameter bit MRS_FIRST        = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_grant,
    input  logic              banks_idle,
    output logic              ready,
    output logic              ref_req,
    output logic              cke,
    output logic              dqm,
    output logic              cmd_cs_n,
    output logic              cmd_ras_n,
    output logic              cmd_cas_n,
    output logic              cmd_we_n,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [BA_W-1:0]   cmd_ba
);

    localparam int STEPS   = INIT_REFRESHES + 2;
    localparam int STEP_W  = $clog2(STEPS);
    localparam int SHORT_A = (T_RC_CYC > T_RP_CYC) ? T_RC_CYC : T_RP_CYC;
    localparam int SHORT_B = (SHORT_A > T_MRD_CYC) ? SHORT_A : T_MRD_CYC;
    localparam int LONGEST = (PWR_WAIT_CYC > SHORT_B) ? PWR_WAIT_CYC : SHORT_B;
    localparam int GAP_W   = $clog2(LONGEST + 1);
    localparam logic [ADDR_W-1:0] AP_MASK = ADDR_W'(1) << AP_BIT;

    seq_state_e        state_q;
    logic [STEP_W-1:0] step_q;
    logic              ready_q;
    logic              dqm_q;
    pins_t             pins_q;
    logic [ADDR_W-1:0] addr_q;

    step_kind_e        init_kind;
    step_kind_e        issue_kind;
    logic              step_last;
    logic              gap_idle;
    logic              gap_load;
    logic [GAP_W-1:0]  gap_val;
    logic              issue_init;
    logic              ref_issue;
    logic              pend_nz;

    sirs_init_order #(
        .INIT_REFRESHES (INIT_REFRESHES),
        .MRS_FIRST      (MRS_FIRST),
        .STEP_W         (STEP_W)
    ) u_order (
        .step (step_q),
        .kind (init_kind),
        .last (step_last)
    );

    sirs_gap_timer #(
        .W       (GAP_W),
        .RST_VAL (PWR_WAIT_CYC)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_val),
        .idle     (gap_idle)
    );

    sirs_refresh_tracker #(
        .INTERVAL (REF_INTERVAL_CYC),
        .MAX_PEND (MAX_POSTPONE)
    ) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (ready_q),
        .issue   (ref_issue),
        .pend_nz (pend_nz)
    );

    // Decide whether a command leaves this cycle and which one.
    always_comb begin
        issue_init = (state_q == ST_INIT) && gap_idle;
        ref_issue  = (state_q == ST_RUN) && gap_idle && pend_nz && ref_grant && banks_idle;
        gap_load   = issue_init || ref_issue;
        issue_kind = ref_issue ? K_REF : init_kind;
    end

    // Recovery distance (minus one) owed by the command being issued.
    always_comb begin
        case (issue_kind)
            K_PALL:  gap_val = GAP_W'(T_RP_CYC - 1);
            K_MRS:   gap_val = GAP_W'(T_MRD_CYC - 1);
            default: gap_val = GAP_W'(T_RC_CYC - 1);
        endcase
    end

    // Sequence state: walk the start-up steps, drain the last gap, then run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_INIT;
            step_q  <= '0;
            ready_q <= 1'b0;
            dqm_q   <= 1'b1;
        end else begin
            case (state_q)
                ST_INIT: begin
                    if (gap_idle) begin
                        if (step_last) state_q <= ST_DRAIN;
                        else           step_q  <= step_q + 1'b1;
                    end
                end
                ST_DRAIN: begin
                    if (gap_idle) begin
                        state_q <= ST_RUN;
                        ready_q <= 1'b1;
                        dqm_q   <= 1'b0;
                    end
                end
                default: begin
                    state_q <= state_q;
                end
            endcase
        end
    end

    // Registered command pins and address; NOP whenever nothing issues.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins_q <= PIN_NOP;
            addr_q <= '0;
        end else begin
            pins_q <= gap_load ? pins_for(issue_kind) : PIN_NOP;
            if (gap_load && issue_kind == K_MRS)       addr_q <= MODE_WORD;
            else if (gap_load && issue_kind == K_PALL) addr_q <= AP_MASK;
            else                                       addr_q <= '0;
        end
    end

    assign {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} = pins_q;
    assign cmd_addr = addr_q;
    assign cmd_ba   = '0;
    assign cke      = 1'b1;
    assign dqm      = dqm_q;
    assign ready    = ready_q;
    assign ref_req  = pend_nz;

endmodule

// File: rtl/sirs_checker.sv
// Protocol checker for the sequencer, bound to every instance of the top.
// Decodes the pins on its own and tracks time since reset and since the
// last command in private counters.
module sirs_checker #(
    parameter int ADDR_W       = 12,
    parameter int BA_W         = 2,
    parameter int AP_BIT       = 10,
    parameter logic [ADDR_W-1:0] MODE_WORD = 'h032,
    parameter int PWR_WAIT_CYC = 25000,
    parameter int T_RP_CYC     = 3,
    parameter int T_RC_CYC     = 9,
    parameter int T_MRD_CYC    = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ref_grant,
    input logic              banks_idle,
    input logic              ready,
    input logic              ref_req,
    input logic              dqm,
    input logic              cmd_cs_n,
    input logic              cmd_ras_n,
    input logic              cmd_cas_n,
    input logic              cmd_we_n,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [BA_W-1:0]   cmd_ba
);

    logic [3:0]  pins;
    logic        is_cmd, is_pall, is_mrs, is_ref;
    logic [31:0] boot_q, since_q;
    logic        seen_q;
    logic [1:0]  last_q;
    int          need_gap;

    assign pins    = {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};
    assign is_cmd  = (pins != 4'b0111);
    assign is_pall = (pins == 4'b0010);
    assign is_mrs  = (pins == 4'b0000);
    assign is_ref  = (pins == 4'b0001);

    // Recovery distance demanded by the previous command's kind.
    always_comb begin
        case (last_q)
            2'd0:    need_gap = T_RP_CYC;
            2'd1:    need_gap = T_MRD_CYC;
            default: need_gap = T_RC_CYC;
        endcase
    end

    // Cycle counters since reset release and since the last command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_q  <= '0;
            since_q <= '0;
            seen_q  <= 1'b0;
            last_q  <= 2'd0;
        end else begin
            if (boot_q != '1) boot_q <= boot_q + 1'b1;
            if (is_cmd) begin
                since_q <= 32'd1;
                seen_q  <= 1'b1;
                last_q  <= is_pall ? 2'd0 : (is_mrs ? 2'd1 : 2'd2);
            end else if (since_q != '1) begin
                since_q <= since_q + 1'b1;
            end
        end
    end

    a_r2_power_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && !seen_q) |-> (boot_q >= PWR_WAIT_CYC));

    a_r6_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && seen_q) |-> (since_q >= need_gap));

    a_r3_pall_ap_bit: assert property (@(posedge clk) disable iff (!rst_n)
        is_pall |-> cmd_addr[AP_BIT]);

    a_r3_mode_word: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> (cmd_addr == MODE_WORD && cmd_ba == '0));

    a_r9_ref_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && is_ref) |-> $past(ref_grant && banks_idle));

    a_r7_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    a_r7_dqm_vs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        dqm ^ ready);

    a_r8_req_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> ready);

    a_r4_no_init_cmd_late: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !(is_pall || is_mrs));

endmodule

bind sdram_init_refresh_seq sirs_checker #(
    .ADDR_W       (ADDR_W),
    .BA_W         (BA_W),
    .AP_BIT       (AP_BIT),
    .MODE_WORD    (MODE_WORD),
    .PWR_WAIT_CYC (PWR_WAIT_CYC),
    .T_RP_CYC     (T_RP_CYC),
    .T_RC_CYC     (T_RC_CYC),
    .T_MRD_CYC    (T_MRD_CYC)
) u_sirs_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_grant  (ref_grant),
    .banks_idle (banks_idle),
    .ready      (ready),
    .ref_req    (ref_req),
    .dqm        (dqm),
    .cmd_cs_n   (cmd_cs_n),
    .cmd_ras_n  (cmd_ras_n),
    .cmd_cas_n  (cmd_cas_n),
    .cmd_we_n   (cmd_we_n),
    .cmd_addr   (cmd_addr),
    .cmd_ba     (cmd_ba)
);

// File: tb/sdram_init_refresh_seq_test.sv
`timescale 1ns/1ps
// Bench: two instances with opposite start-up orders on a small timing set;
// every command is logged and compared with an arithmetic schedule.
module sdram_init_refresh_seq_test;

    localparam int AW   = 12;
    localparam int P    = 20;
    localparam int TRP  = 3;
    localparam int TRC  = 5;
    localparam int TMRD = 2;
    localparam int NREF = 8;
    localparam int IV   = 40;
    localparam int MAXP = 3;
    localparam logic [AW-1:0] MW = 12'h032;
    localparam int LOGN = 32;

    logic clk = 1'b0;
    logic rst_n;
    logic grant, idle;
    int   cyc;
    int   nchk = 0, nfail = 0;
    bit   done = 1'b0;

    logic u_rdy, u_req, u_cke, u_dqm, u_cs, u_ras, u_cas, u_we;
    logic [AW-1:0] u_addr;
    logic [1:0]    u_ba;
    logic a_rdy, a_req, a_cke, a_dqm, a_cs, a_ras, a_cas, a_we;
    logic [AW-1:0] a_addr;
    logic [1:0]    a_ba;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    sdram_init_refresh_seq #(
        .ADDR_W(AW), .MODE_WORD(MW), .PWR_WAIT_CYC(P), .T_RP_CYC(TRP),
        .T_RC_CYC(TRC), .T_MRD_CYC(TMRD), .INIT_REFRESHES(NREF),
        .REF_INTERVAL_CYC(IV), .MAX_POSTPONE(MAXP), .MRS_FIRST(1'b1)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ref_grant(grant), .banks_idle(idle),
        .ready(u_rdy), .ref_req(u_req), .cke(u_cke), .dqm(u_dqm),
        .cmd_cs_n(u_cs), .cmd_ras_n(u_ras), .cmd_cas_n(u_cas), .cmd_we_n(u_we),
        .cmd_addr(u_addr), .cmd_ba(u_ba)
    );

    sdram_init_refresh_seq #(
        .ADDR_W(AW), .MODE_WORD(MW), .PWR_WAIT_CYC(P), .T_RP_CYC(TRP),
        .T_RC_CYC(TRC), .T_MRD_CYC(TMRD), .INIT_REFRESHES(NREF),
        .REF_INTERVAL_CYC(IV), .MAX_POSTPONE(MAXP), .MRS_FIRST(1'b0)
    ) uut_alt (
        .clk(clk), .rst_n(rst_n), .ref_grant(grant), .banks_idle(idle),
        .ready(a_rdy), .ref_req(a_req), .cke(a_cke), .dqm(a_dqm),
        .cmd_cs_n(a_cs), .cmd_ras_n(a_ras), .cmd_cas_n(a_cas), .cmd_we_n(a_we),
        .cmd_addr(a_addr), .cmd_ba(a_ba)
    );

    int       u_cyc [LOGN];
    logic [3:0] u_pin [LOGN];
    logic [AW-1:0] u_adr [LOGN];
    int       u_n = 0;
    int       a_cyc [LOGN];
    logic [3:0] a_pin [LOGN];
    logic [AW-1:0] a_adr [LOGN];
    int       a_n = 0;
    int       cke_bad = 0;

    int e_u [NREF+2];
    int e_a [NREF+2];
    logic [3:0] k_u [NREF+2];
    logic [3:0] k_a [NREF+2];
    int rt [8];
    int R;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    // Build the expected schedules from the requirement arithmetic.
    task automatic build_expect();
        int c0;
        c0 = P + 1;
        e_u[0] = c0;            k_u[0] = 4'b0010;
        e_u[1] = c0 + TRP;      k_u[1] = 4'b0000;
        for (int i = 2; i < NREF + 2; i++) begin
            e_u[i] = c0 + TRP + TMRD + (i - 2) * TRC;
            k_u[i] = 4'b0001;
        end
        e_a[0] = c0;            k_a[0] = 4'b0010;
        for (int i = 1; i <= NREF; i++) begin
            e_a[i] = c0 + TRP + (i - 1) * TRC;
            k_a[i] = 4'b0001;
        end
        e_a[NREF+1] = c0 + TRP + NREF * TRC;
        k_a[NREF+1] = 4'b0000;
        R = e_u[NREF+1] + TRC;
        rt[0] = R + IV + 1;
        rt[1] = R + 2*IV + 1;
        for (int k = 0; k < MAXP; k++) rt[2+k] = R + 7*IV + 5 + k*TRC;
        rt[5] = R + 8*IV + 1;
        rt[6] = R + 9*IV + 15;
        rt[7] = R + 10*IV + 1;
    endtask

    // Record every non-NOP command of both instances.
    task automatic sample();
        if (u_cke !== 1'b1 || a_cke !== 1'b1) cke_bad++;
        if ({u_cs,u_ras,u_cas,u_we} != 4'b0111 && u_n < LOGN) begin
            u_cyc[u_n] = cyc; u_pin[u_n] = {u_cs,u_ras,u_cas,u_we}; u_adr[u_n] = u_addr; u_n++;
        end
        if ({a_cs,a_ras,a_cas,a_we} != 4'b0111 && a_n < LOGN) begin
            a_cyc[a_n] = cyc; a_pin[a_n] = {a_cs,a_ras,a_cas,a_we}; a_adr[a_n] = a_addr; a_n++;
        end
    endtask

    initial begin
        #(8 * 5000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        int endc;
        rst_n = 1'b0; grant = 1'b1; idle = 1'b1;
        build_expect();
        endc = R + 10*IV + 10;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(u_cke && u_dqm && !u_rdy && !u_req, "R1 reset uut cke/dqm/ready/req", {u_cke,u_dqm,u_rdy,u_req}, 4'b1100);
        chk({u_cs,u_ras,u_cas,u_we} == 4'b0111, "R1 reset uut NOP", {u_cs,u_ras,u_cas,u_we}, 4'b0111);
        chk(a_cke && a_dqm && !a_rdy && !a_req, "R1 reset alt cke/dqm/ready/req", {a_cke,a_dqm,a_rdy,a_req}, 4'b1100);
        rst_n = 1'b1;
        while (cyc < endc) begin
            @(negedge clk);
            sample();
            if (cyc == 1)
                chk({u_cs,u_ras,u_cas,u_we} == 4'b0111 && !u_rdy, "R1 first cycle NOP", {u_cs,u_ras,u_cas,u_we}, 4'b0111);
            if (cyc == R - 1) begin
                chk(!u_rdy && u_dqm, "R7 uut not ready before", u_rdy, 0);
                chk(!a_rdy && a_dqm, "R7 alt not ready before", a_rdy, 0);
            end
            if (cyc == R) begin
                chk(u_rdy && !u_dqm, "R7 uut ready and dqm low", {u_rdy,u_dqm}, 2'b10);
                chk(a_rdy && !a_dqm, "R7 alt ready and dqm low", {a_rdy,a_dqm}, 2'b10);
                chk(!u_req, "R8 no request at ready", u_req, 0);
            end
            if (cyc == R + IV - 1) chk(!u_req, "R8 request not before interval", u_req, 0);
            if (cyc == R + IV)     chk(u_req && a_req, "R8 request after interval", u_req, 1);
            if (cyc == R + IV + 1) chk(!u_req && !a_req, "R11 request falls with refresh", u_req, 0);
            if (cyc == R + 7*IV + 2) chk(u_req, "R10 request held while postponed", u_req, 1);
            if (cyc == R + 7*IV + 16) chk(!u_req, "R11 request low after burst", u_req, 0);
            if (cyc == R + 9*IV + 5) chk(u_req, "R9 request waits for idle banks", u_req, 1);
            // stimulus
            if (cyc == R + 2*IV + 4) grant = 1'b0;
            if (cyc == R + 7*IV + 4) grant = 1'b1;
            if (cyc == R + 8*IV + 4) idle  = 1'b0;
            if (cyc == R + 9*IV + 14) idle = 1'b1;
        end

        chk(cke_bad == 0, "R7 cke always high", cke_bad, 0);
        chk(u_n == NREF + 2 + 8, "R5 uut command count", u_n, NREF + 10);
        chk(a_n == NREF + 2 + 8, "R5 alt command count", a_n, NREF + 10);
        chk(u_cyc[0] == P + 1, "R2 uut first command cycle", u_cyc[0], P + 1);
        chk(a_cyc[0] == P + 1, "R2 alt first command cycle", a_cyc[0], P + 1);
        for (int i = 0; i < NREF + 2; i++) begin
            chk(u_cyc[i] == e_u[i], "R6 uut init command cycle", u_cyc[i], e_u[i]);
            chk(u_pin[i] == k_u[i], "R4 uut init command kind", u_pin[i], k_u[i]);
            chk(a_cyc[i] == e_a[i], "R6 alt init command cycle", a_cyc[i], e_a[i]);
            chk(a_pin[i] == k_a[i], "R4 alt init command kind", a_pin[i], k_a[i]);
        end
        chk(u_adr[0][10] == 1'b1, "R3 uut precharge-all A10", u_adr[0][10], 1);
        chk(u_adr[1] == MW, "R3 uut mode word", u_adr[1], MW);
        chk(a_adr[NREF+1] == MW, "R3 alt mode word", a_adr[NREF+1], MW);
        for (int k = 0; k < 8; k++) begin
            chk(u_cyc[NREF+2+k] == rt[k], "R10 uut runtime refresh cycle", u_cyc[NREF+2+k], rt[k]);
            chk(u_pin[NREF+2+k] == 4'b0001, "R3 uut runtime refresh pins", u_pin[NREF+2+k], 4'b0001);
            chk(a_cyc[NREF+2+k] == rt[k], "R9 alt runtime refresh cycle", a_cyc[NREF+2+k], rt[k]);
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule